// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Bank

This block is a bank of up to 32 general-purpose lines behind a 32-bit register interface. Each line works in one of three ways. It can be a general input, a general output whose value is held in an output register, or an interrupt input. An interrupt input is sensed either by level or by edge. Polarity is chosen per line, and an optional mode lets an edge-sensed line react to both transitions. Pin levels pass through a two-flop synchronizer before they are read or sensed.

Events land in a status register. Software clears an edge event by writing ones to a clear register. Level events cannot be cleared this way, because they follow the pin. A per-line enable has two addresses: one address sets enable bits and the other drops them. The single interrupt output is high while any line is both pending and enabled.

The register bus has no back-pressure. Every cycle with `bus_valid` high is one complete access. A write takes effect at that clock edge. Read data appears on `bus_rdata` after that same edge and holds until the next read. A chattering-filter register exists only as a read/write placeholder. The parameter `BOTH_EDGE` removes the both-edge register; when it is removed, that register reads as zero.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is 0 and `pin_oe` is all zeros.
- R2: A line drives its pin (`pin_oe` bit 1) only when its mode bit (offset 0x00) is 0 and its direction bit (offset 0x04) is 1. `pin_out` equals the output register (offset 0x08), and a read of that offset returns the value written.
- R3: A read of offset 0x0C returns the pin levels after a two-flop synchronizer.
- R4: A line with mode bit 1 and sense bit 0 (offset 0x24) has a level-sensed status bit. The bit equals the synchronized pin XOR its polarity bit (offset 0x20; 0 means active high). A clear write does not hold it low.
- R5: A line with mode bit 1 and sense bit 1 sets its status bit on a rising edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. The bit stays set until it is cleared.
- R6: When both-edge bit (offset 0x4C) is 1, an edge-sensed line sets status on either transition, whatever its polarity. The register reads back as written.
- R7: Writing 1 to a bit of offset 0x14 clears that edge status bit, and writing 0 leaves it unchanged. When an edge arrives in the same cycle as the clear, the bit stays set.
- R8: Writing 1s to offset 0x1C sets enable bits. Writing to offset 0x18 drops every enable bit written as 0 and keeps the others. Offset 0x18 reads the enable bits. `irq` is 1 exactly when status AND enable is nonzero.
- R9: A line whose mode bit is 0 never sets its status bit, whatever its pin does.
- R10: Offset 0x28 reads back the value written to it. Offsets 0x14 and 0x1C read zero. Status is read at offset 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the read's clock edge |
| pin_in | input | LINES | Pin levels, asynchronous |
| pin_out | output | LINES | Output register value |
| pin_oe | output | LINES | Per-line output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a new edge arriving in the exact cycle of a clear write. To get there, the pin must change three clock edges before the write. That covers two synchronizer stages, plus the edge-detect stage at the same edge that captures the write. The bench drives the pin on a falling clock edge, waits two cycles, and then issues the clear. It then reads status back to show that the event survived. A second clear with no edge then shows that the bit does drop.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_AW = 7;
  localparam int unsigned BUS_DW = 32;
  localparam logic [BUS_AW-1:0] OFS_MODE   = 7'h00;
  localparam logic [BUS_AW-1:0] OFS_DIR    = 7'h04;
  localparam logic [BUS_AW-1:0] OFS_DOUT   = 7'h08;
  localparam logic [BUS_AW-1:0] OFS_DIN    = 7'h0C;
  localparam logic [BUS_AW-1:0] OFS_STAT   = 7'h10;
  localparam logic [BUS_AW-1:0] OFS_CLR    = 7'h14;
  localparam logic [BUS_AW-1:0] OFS_MASKDN = 7'h18;
  localparam logic [BUS_AW-1:0] OFS_MASKUP = 7'h1C;
  localparam logic [BUS_AW-1:0] OFS_POL    = 7'h20;
  localparam logic [BUS_AW-1:0] OFS_SENSE  = 7'h24;
  localparam logic [BUS_AW-1:0] OFS_FILT   = 7'h28;
  localparam logic [BUS_AW-1:0] OFS_BOTH   = 7'h4C;

  typedef struct packed {
    logic is_irq;
    logic is_edge;
    logic active_low;
    logic both;
  } line_cfg_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_prev
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      stage1   <= raw;
      lvl      <= stage1;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/gpio_line_sense.sv
module gpio_line_sense
  import gpio_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cfg_t cfg,
  input  logic      lvl,
  input  logic      lvl_prev,
  input  logic      clr,
  output logic      status
);
  logic rise, fall, hit;

  always_comb begin
    rise = lvl & ~lvl_prev;
    fall = ~lvl & lvl_prev;
    if (cfg.both) hit = rise | fall;
    else          hit = cfg.active_low ? fall : rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            status <= 1'b0;
    else if (!cfg.is_irq)  status <= 1'b0;
    else if (!cfg.is_edge) status <= lvl ^ cfg.active_low;
    else                   status <= hit | (status & ~clr);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES     = 32,
  parameter bit          BOTH_EDGE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [BUS_DW-1:0]   bus_wdata,
  output logic [BUS_DW-1:0]   bus_rdata,
  input  logic [LINES-1:0]    pin_in,
  output logic [LINES-1:0]    pin_out,
  output logic [LINES-1:0]    pin_oe,
  output logic                irq
);
  logic [LINES-1:0] mode_q, dir_q, dout_q, pol_q, edge_q, filt_q, mask_q, both_q;
  logic [LINES-1:0] status_q, sync_lvl, sync_prev, clr_vec, wd;
  logic             wr_en, rd_en;
  logic [BUS_DW-1:0] rd_mux;

  assign wr_en   = bus_valid & bus_write;
  assign rd_en   = bus_valid & ~bus_write;
  assign wd      = bus_wdata[LINES-1:0];
  assign clr_vec = (wr_en && bus_addr == OFS_CLR) ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; dir_q <= '0; dout_q <= '0; pol_q <= '0;
      edge_q <= '0; filt_q <= '0; mask_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        OFS_MODE:   mode_q <= wd;
        OFS_DIR:    dir_q  <= wd;
        OFS_DOUT:   dout_q <= wd;
        OFS_POL:    pol_q  <= wd;
        OFS_SENSE:  edge_q <= wd;
        OFS_FILT:   filt_q <= wd;
        OFS_MASKDN: mask_q <= mask_q & wd;
        OFS_MASKUP: mask_q <= mask_q | wd;
        default: ;
      endcase
    end
  end

  generate
    if (BOTH_EDGE) begin : g_both
      always_ff @(posedge clk) begin
        if (!rst_n) both_q <= '0;
        else if (wr_en && bus_addr == OFS_BOTH) both_q <= wd;
      end
    end else begin : g_noboth
      assign both_q = '0;
    end
  endgenerate

  gpio_pin_sync #(.WIDTH(LINES)) i_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .lvl(sync_lvl), .lvl_prev(sync_prev)
  );

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      line_cfg_t cfg;
      assign cfg = '{is_irq: mode_q[i], is_edge: edge_q[i],
                     active_low: pol_q[i], both: both_q[i]};
      gpio_line_sense i_sense (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .lvl(sync_lvl[i]),
        .lvl_prev(sync_prev[i]), .clr(clr_vec[i]), .status(status_q[i])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_MODE:   rd_mux[LINES-1:0] = mode_q;
      OFS_DIR:    rd_mux[LINES-1:0] = dir_q;
      OFS_DOUT:   rd_mux[LINES-1:0] = dout_q;
      OFS_DIN:    rd_mux[LINES-1:0] = sync_lvl;
      OFS_STAT:   rd_mux[LINES-1:0] = status_q;
      OFS_MASKDN: rd_mux[LINES-1:0] = mask_q;
      OFS_POL:    rd_mux[LINES-1:0] = pol_q;
      OFS_SENSE:  rd_mux[LINES-1:0] = edge_q;
      OFS_FILT:   rd_mux[LINES-1:0] = filt_q;
      OFS_BOTH:   rd_mux[LINES-1:0] = both_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq     = |(status_q & mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned LINES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] mode_q,
  input logic [LINES-1:0] edge_q,
  input logic [LINES-1:0] pol_q,
  input logic [LINES-1:0] mask_q,
  input logic [LINES-1:0] status_q,
  input logic [LINES-1:0] sync_lvl,
  input logic [LINES-1:0] clr_vec,
  input logic             irq
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_GENIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((status_q & ~$past(mode_q)) == '0)); // R9
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (((status_q ^ $past(sync_lvl ^ pol_q)) & $past(mode_q & ~edge_q)) == '0)); // R4
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(status_q & mode_q & edge_q & ~clr_vec) & ~status_q) == '0)); // R5
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0)); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0)); // R8
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.LINES(LINES)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .edge_q(edge_q), .pol_q(pol_q),
  .mask_q(mask_q), .status_q(status_q), .sync_lvl(sync_lvl), .clr_vec(clr_vec),
  .irq(irq)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    pin_in[idx] = v;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    foreach (a_list[k]) begin
      rd(a_list[k], d);
      chk("R1 reg", d, 32'h0);
    end
  endtask
  logic [6:0] a_list [10] = '{7'h00, 7'h04, 7'h08, 7'h10, 7'h18, 7'h20, 7'h24, 7'h28, 7'h4C, 7'h0C};

  task automatic t_io();
    logic [31:0] d;
    wr(7'h04, 32'h0000FFFF);
    wr(7'h08, 32'hA5A51234);
    chk("R2 oe", pin_oe, 32'h0000FFFF);
    chk("R2 out", pin_out, 32'hA5A51234);
    rd(7'h08, d);
    chk("R2 readback", d, 32'hA5A51234);
    wr(7'h00, 32'h00000001);
    chk("R2 oe irq-mode line", pin_oe, 32'h0000FFFE);
    wr(7'h00, 32'h0);
    wr(7'h04, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'h12345678;
    repeat (3) @(negedge clk);
    rd(7'h0C, d);
    chk("R3 input", d, 32'h12345678);
    @(negedge clk);
    pin_in = 32'h0;
    settle();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(7'h20, 32'h2);
    wr(7'h00, 32'hF);
    settle();
    rd(7'h10, d);
    chk("R4 active-low idle", d, 32'h2);
    set_pin(0, 1'b1);
    rd(7'h10, d);
    chk("R4 active-high", d, 32'h3);
    wr(7'h1C, 32'h1);
    settle();
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    wr(7'h14, 32'h3);
    settle();
    rd(7'h10, d);
    chk("R4 clear no hold", d, 32'h3);
    set_pin(0, 1'b0);
    chk("R8 irq off unmasked line", {31'b0, irq}, 32'h0);
    wr(7'h00, 32'h0);
    wr(7'h20, 32'h0);
    wr(7'h18, 32'h0);
    rd(7'h18, d);
    chk("R8 mask down", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(7'h24, 32'h30);
    wr(7'h20, 32'h20);
    wr(7'h00, 32'h30);
    wr(7'h14, 32'hFFFFFFFF);
    @(negedge clk);
    pin_in[5:4] = 2'b11;
    settle();
    rd(7'h10, d);
    chk("R5 rise only", d, 32'h10);
    @(negedge clk);
    pin_in[5:4] = 2'b00;
    settle();
    rd(7'h10, d);
    chk("R5 latched and fall", d, 32'h30);
    wr(7'h14, 32'h10);
    rd(7'h10, d);
    chk("R7 clear one", d, 32'h20);
    wr(7'h14, 32'h0);
    rd(7'h10, d);
    chk("R7 zero no effect", d, 32'h20);
    wr(7'h14, 32'h20);
    wr(7'h00, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(7'h4C, 32'h40);
    rd(7'h4C, d);
    chk("R6 readback", d, 32'h40);
    wr(7'h24, 32'h40);
    wr(7'h00, 32'h40);
    set_pin(6, 1'b1);
    rd(7'h10, d);
    chk("R6 rise", d, 32'h40);
    wr(7'h14, 32'h40);
    set_pin(6, 1'b0);
    rd(7'h10, d);
    chk("R6 fall", d, 32'h40);
    @(negedge clk);
    pin_in[6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 7'h14; bus_wdata = 32'h40;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(7'h10, d);
    chk("R7 edge beats clear", d, 32'h40);
    wr(7'h14, 32'h40);
    rd(7'h10, d);
    chk("R7 clear later", d, 32'h0);
    wr(7'h1C, 32'h41);
    set_pin(6, 1'b0);
    chk("R8 irq from edge", {31'b0, irq}, 32'h1);
    wr(7'h18, 32'hFFFFFFBF);
    @(negedge clk);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(7'h18, d);
    chk("R8 mask keeps ones", d, 32'h1);
    wr(7'h00, 32'h0);
  endtask

  task automatic t_general();
    logic [31:0] d;
    set_pin(8, 1'b1);
    set_pin(8, 1'b0);
    rd(7'h10, d);
    chk("R9 general line quiet", d, 32'h0);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    wr(7'h28, 32'hDEADBEEF);
    rd(7'h28, d);
    chk("R10 filter", d, 32'hDEADBEEF);
    rd(7'h14, d);
    chk("R10 clear reads zero", d, 32'h0);
    rd(7'h1C, d);
    chk("R10 mask-up reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io();
    t_input();
    t_level();
    t_edge();
    t_both();
    t_general();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule